// File: doc/BRIEF.md
# Slave-Port Arbiter with Idle Connection Policy

This block decides which master of a multi-master bus matrix owns one slave port. Every master has a request line. The block returns a registered one-hot grant and a flag that says whether the master now requesting is already connected, so its access pays no setup cycle. Among competing masters the winner is picked round-robin, starting with the master just after the current owner.

Two limits force a new arbitration while a master holds the port. The first is a slot timer, which counts bus cycles of ownership. The second is a beat limit for bursts of undefined length. When either limit expires and another master is waiting, the burst is cut and the waiting master takes over. When nobody else is waiting, the owner keeps the port with no gap.

When an access ends and no request is pending, a programmable policy sets what happens next. The port can drop every master, stay with the master that used it last, or connect to one fixed master. The settings sit in a small register. A write-lock input blocks updates to that register.

Top module: `sparb_top`

## Requirements
- R1: After reset, `grant_o` and `no_wait_o` are 0, the idle policy is "none", the slot limit is 511 cycles and the beat limit is unlimited.
- R2: `grant_o` has at most one bit set. It changes only on a clock edge.
- R3: When the port is free, or the owner's last beat (`beat_i` and `last_i` both high) has been accepted, the next owner is the first requesting master found in the order owner+1, owner+2, … wrapping around, with the current owner checked last. The new grant appears after that edge.
- R4: With slot limit L > 0, an owner that keeps requesting without finishing loses the grant on its L-th active cycle if another master is requesting. The winner is the round-robin choice among the other requesters.
- R5: When the slot limit expires and no other master is requesting, the counter reloads and the owner keeps its grant with no gap.
- R6: A slot limit of 0 disables the slot timer, so a burst is never cut on elapsed cycles.
- R7: The beat limit code sets how many beats (`beat_i` high) an owner may take before it loses the grant to a competitor: 0 = unlimited, 1 = one beat, 2 = four, 3 = eight, 4 = sixteen, 5–7 = unlimited. Cycles without a beat are not counted.
- R8: Idle policy 0, and also 3: when nobody is requesting, the grant clears on the next edge. A later request then sees `no_wait_o` = 0 until it is granted.
- R9: Idle policy 1: when nobody is requesting, the grant stays with the connected master, so its next request sees `no_wait_o` = 1 at once.
- R10: Idle policy 2: when nobody is requesting, the grant goes to master `cfg_fixed_i` (as stored).
- R11: A configuration write (`cfg_wr_i` high) updates all stored fields on the edge, unless `cfg_lock_i` is high. In that case the stored fields are unchanged.
- R12: `no_wait_o` is high exactly when a master holds the grant and that same master is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N | Request line per master |
| beat_i | input | 1 | A data beat of the owner is accepted this cycle |
| last_i | input | 1 | The accepted beat ends the owner's access |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_lock_i | input | 1 | Write lock: writes are ignored while high |
| cfg_slot_i | input | SLOT_W | Slot-cycle limit to store (0 disables) |
| cfg_idle_mode_i | input | 2 | Idle policy to store: 0 none, 1 last, 2 fixed, 3 none |
| cfg_fixed_i | input | IDX_W | Fixed idle master index to store |
| cfg_ulb_i | input | 3 | Beat-limit code to store |
| grant_o | output | N | One-hot grant, or all zero |
| no_wait_o | output | 1 | Requesting master is already connected |

## Verification
The checker assumes that `beat_i` and `last_i` describe the master holding the grant. A beat is meaningful only in a cycle where that owner requests. The checker also assumes that a master keeps requesting after its last beat only when it wants a new access. The stimulus follows both rules: it raises `beat_i` only while the granted master's request is high, and it changes inputs on falling edges. Configuration writes are made with requests idle, or with only the owner requesting, so that a policy change never lands at the same moment as an arbitration whose result is checked.

// File: rtl/sparb_pkg.sv
package sparb_pkg;

    typedef enum logic [1:0] {
        IDLE_NONE  = 2'd0,
        IDLE_LAST  = 2'd1,
        IDLE_FIXED = 2'd2,
        IDLE_ALT   = 2'd3
    } idle_mode_e;

    localparam int BEAT_W = 5;

    // 0 means unlimited
    function automatic logic [BEAT_W-1:0] beat_limit(input logic [2:0] code);
        case (code)
            3'd1:    beat_limit = BEAT_W'(1);
            3'd2:    beat_limit = BEAT_W'(4);
            3'd3:    beat_limit = BEAT_W'(8);
            3'd4:    beat_limit = BEAT_W'(16);
            default: beat_limit = '0;
        endcase
    endfunction

endpackage

// File: rtl/sparb_cfg.sv
module sparb_cfg #(
    parameter int SLOT_W = 9,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              lock_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [1:0]        mode_i,
    input  logic [IDX_W-1:0]  fixed_i,
    input  logic [2:0]        ulb_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [1:0]        mode_o,
    output logic [IDX_W-1:0]  fixed_o,
    output logic [2:0]        ulb_o
);
    localparam logic [SLOT_W-1:0] SLOT_RST = {SLOT_W{1'b1}};

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [1:0]        mode;
        logic [IDX_W-1:0]  fixed;
        logic [2:0]        ulb;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && !lock_i) begin
            cfg_d.slot  = slot_i;
            cfg_d.mode  = mode_i;
            cfg_d.fixed = fixed_i;
            cfg_d.ulb   = ulb_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.slot  <= SLOT_RST;
            cfg_q.mode  <= sparb_pkg::IDLE_NONE;
            cfg_q.fixed <= '0;
            cfg_q.ulb   <= 3'd0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign slot_o  = cfg_q.slot;
    assign mode_o  = cfg_q.mode;
    assign fixed_o = cfg_q.fixed;
    assign ulb_o   = cfg_q.ulb;
endmodule

// File: rtl/sparb_rr.sv
module sparb_rr #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] base_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the farthest offset down so the nearest requester wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int p;
            p = int'(base_i) + k;
            if (p >= N) p = p - N;
            if (req_i[p]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(p);
            end
        end
    end
endmodule

// File: rtl/sparb_top.sv
module sparb_top #(
    parameter int N      = 4,
    parameter int SLOT_W = 9,
    parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_i,
    input  logic              beat_i,
    input  logic              last_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_lock_i,
    input  logic [SLOT_W-1:0] cfg_slot_i,
    input  logic [1:0]        cfg_idle_mode_i,
    input  logic [IDX_W-1:0]  cfg_fixed_i,
    input  logic [2:0]        cfg_ulb_i,
    output logic [N-1:0]      grant_o,
    output logic              no_wait_o
);
    import sparb_pkg::*;

    localparam int CW = SLOT_W + 1;
    localparam int BW = BEAT_W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);
    localparam logic [N-1:0]     ONE_N    = {{(N-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              conn;
        logic [IDX_W-1:0]  owner;
        logic [SLOT_W-1:0] slot_cnt;
        logic [BEAT_W-1:0] beat_cnt;
    } st_t;

    st_t st_d, st_q;

    logic [SLOT_W-1:0] slot_q;
    logic [1:0]        mode_q;
    logic [IDX_W-1:0]  fixed_q;
    logic [2:0]        ulb_q;

    sparb_cfg #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .lock_i  (cfg_lock_i),
        .slot_i  (cfg_slot_i),
        .mode_i  (cfg_idle_mode_i),
        .fixed_i (cfg_fixed_i),
        .ulb_i   (cfg_ulb_i),
        .slot_o  (slot_q),
        .mode_o  (mode_q),
        .fixed_o (fixed_q),
        .ulb_o   (ulb_q)
    );

    logic [N-1:0]      owner_oh;
    logic [N-1:0]      others;
    logic [IDX_W-1:0]  rr_base;
    logic              all_found, oth_found;
    logic [IDX_W-1:0]  all_idx, oth_idx;
    logic [BEAT_W-1:0] blim;
    logic              end_acc, owner_req, active, slot_exp, beat_exp;

    assign owner_oh = st_q.conn ? (ONE_N << st_q.owner) : '0;
    assign others   = req_i & ~owner_oh;
    assign rr_base  = (st_q.owner == LAST_IDX) ? '0 : st_q.owner + 1'b1;
    assign blim     = beat_limit(ulb_q);

    sparb_rr #(.N(N), .IDX_W(IDX_W)) u_rr_all (
        .req_i   (req_i),
        .base_i  (rr_base),
        .found_o (all_found),
        .idx_o   (all_idx)
    );

    sparb_rr #(.N(N), .IDX_W(IDX_W)) u_rr_oth (
        .req_i   (others),
        .base_i  (rr_base),
        .found_o (oth_found),
        .idx_o   (oth_idx)
    );

    always_comb begin
        end_acc   = st_q.conn && beat_i && last_i;
        owner_req = st_q.conn && req_i[st_q.owner];
        active    = owner_req && !end_acc;
        slot_exp  = (slot_q != '0) &&
                    ((CW'(st_q.slot_cnt) + CW'(1)) >= CW'(slot_q));
        beat_exp  = beat_i && (blim != '0) &&
                    ((BW'(st_q.beat_cnt) + BW'(1)) >= BW'(blim));

        st_d = st_q;
        if (active) begin
            if ((slot_exp || beat_exp) && oth_found) begin
                st_d.owner    = oth_idx;
                st_d.slot_cnt = '0;
                st_d.beat_cnt = '0;
            end else begin
                if (slot_q == '0 || slot_exp) st_d.slot_cnt = '0;
                else                          st_d.slot_cnt = st_q.slot_cnt + 1'b1;
                if (blim == '0 || beat_exp)   st_d.beat_cnt = '0;
                else if (beat_i)              st_d.beat_cnt = st_q.beat_cnt + 1'b1;
            end
        end else begin
            st_d.slot_cnt = '0;
            st_d.beat_cnt = '0;
            if (all_found) begin
                st_d.conn  = 1'b1;
                st_d.owner = all_idx;
            end else begin
                case (idle_mode_e'(mode_q))
                    IDLE_LAST: st_d.conn = st_q.conn;
                    IDLE_FIXED: begin
                        if (32'(fixed_q) < N) begin
                            st_d.conn  = 1'b1;
                            st_d.owner = fixed_q;
                        end else begin
                            st_d.conn = 1'b0;
                        end
                    end
                    default: st_d.conn = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o   = owner_oh;
    assign no_wait_o = owner_req;
endmodule

// File: rtl/sparb_chk.sv
module sparb_chk #(
    parameter int N      = 4,
    parameter int SLOT_W = 9,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      req_i,
    input logic              beat_i,
    input logic              last_i,
    input logic              cfg_wr_i,
    input logic              cfg_lock_i,
    input logic [N-1:0]      grant_o,
    input logic [SLOT_W-1:0] slot_q,
    input logic [1:0]        mode_q,
    input logic [IDX_W-1:0]  fixed_q,
    input logic [2:0]        ulb_q
);
    localparam logic [N-1:0] ONE_N = {{(N-1){1'b0}}, 1'b1};

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));                                                   // R2

    AST_BREAK_NEEDS_RIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grant_o) != '0 && grant_o != '0 && grant_o != $past(grant_o) &&
         ($past(req_i) & $past(grant_o)) != '0 && !$past(beat_i && last_i))
        |-> (($past(req_i) & ~$past(grant_o)) != '0));                         // R4

    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) == '0 && ($past(mode_q) == 2'd0 || $past(mode_q) == 2'd3))
        |-> (grant_o == '0));                                                 // R8

    AST_IDLE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) == '0 && $past(mode_q) == 2'd1)
        |-> (grant_o == $past(grant_o)));                                     // R9

    AST_IDLE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) == '0 && $past(mode_q) == 2'd2 && 32'($past(fixed_q)) < N)
        |-> (grant_o == (ONE_N << $past(fixed_q))));                          // R10

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_lock_i)
        |=> $stable({slot_q, mode_q, fixed_q, ulb_q}));                       // R11
endmodule

bind sparb_top sparb_chk #(.N(N), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .beat_i     (beat_i),
    .last_i     (last_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_lock_i (cfg_lock_i),
    .grant_o    (grant_o),
    .slot_q     (slot_q),
    .mode_q     (mode_q),
    .fixed_q    (fixed_q),
    .ulb_q      (ulb_q)
);

// File: tb/tb_sparb_top.sv
module tb_sparb_top;
    localparam int N = 4;
    localparam int SLOT_W = 9;
    localparam int IDX_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic beat = 1'b0, last = 1'b0;
    logic cfg_wr = 1'b0, cfg_lock = 1'b0;
    logic [SLOT_W-1:0] cfg_slot = '0;
    logic [1:0] cfg_mode = '0;
    logic [IDX_W-1:0] cfg_fixed = '0;
    logic [2:0] cfg_ulb = '0;
    logic [N-1:0] grant;
    logic no_wait;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sparb_top #(.N(N), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .beat_i(beat), .last_i(last),
        .cfg_wr_i(cfg_wr), .cfg_lock_i(cfg_lock), .cfg_slot_i(cfg_slot),
        .cfg_idle_mode_i(cfg_mode), .cfg_fixed_i(cfg_fixed), .cfg_ulb_i(cfg_ulb),
        .grant_o(grant), .no_wait_o(no_wait)
    );

    // req, beat, last, expected grant, expected no_wait (idle policy 0)
    localparam logic [10:0] VEC [0:11] = '{
        {4'b0001, 1'b0, 1'b0, 4'b0001, 1'b1},
        {4'b0001, 1'b1, 1'b0, 4'b0001, 1'b1},
        {4'b0011, 1'b1, 1'b1, 4'b0010, 1'b1},
        {4'b0010, 1'b1, 1'b0, 4'b0010, 1'b1},
        {4'b0110, 1'b1, 1'b0, 4'b0010, 1'b1},
        {4'b0100, 1'b0, 1'b0, 4'b0100, 1'b1},
        {4'b0100, 1'b1, 1'b1, 4'b0100, 1'b1},
        {4'b0000, 1'b0, 1'b0, 4'b0000, 1'b0},
        {4'b1000, 1'b0, 1'b0, 4'b1000, 1'b1},
        {4'b1001, 1'b1, 1'b1, 4'b0001, 1'b1},
        {4'b1000, 1'b0, 1'b0, 4'b1000, 1'b1},
        {4'b0000, 1'b0, 1'b0, 4'b0000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, settle.
    task automatic step(input logic [N-1:0] r, input logic b, input logic l);
        @(negedge clk);
        req = r; beat = b; last = l; cfg_wr = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic lk, input logic [SLOT_W-1:0] s, input logic [1:0] m,
                             input logic [IDX_W-1:0] f, input logic [2:0] u);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_lock = lk; cfg_slot = s; cfg_mode = m; cfg_fixed = f; cfg_ulb = u;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0; cfg_lock = 1'b0;
    endtask

    // Set inputs at the falling edge and sample before the next rising edge.
    task automatic pre_edge(input logic [N-1:0] r);
        @(negedge clk);
        req = r; beat = 1'b0; last = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset grant", grant, 0);
        check("R1 reset no_wait", no_wait, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: default slot 511 and unlimited beats
        step(4'b0001, 1'b0, 1'b0);
        for (int k = 1; k <= 511; k++) begin
            step(4'b0011, 1'b1, 1'b0);
            if (k == 510) check("R1 default slot holds", grant, 4'b0001);
            if (k == 511) check("R1 default slot expires", grant, 4'b0010);
        end
        step(4'b0000, 1'b0, 1'b0);
        check("R1 default idle none", grant, 0);

        // Table: R3 round-robin, R8 idle none, R12 no_wait
        foreach (VEC[i]) begin
            step(VEC[i][10:7], VEC[i][6], VEC[i][5]);
            check($sformatf("R3 table grant row %0d", i), grant, VEC[i][4:1]);
            check($sformatf("R12 table no_wait row %0d", i), no_wait, VEC[i][0]);
        end

        // R8: disconnected master pays a cycle
        pre_edge(4'b0001);
        check("R8 penalty no_wait", no_wait, 0);
        @(posedge clk); #1;
        check("R8 granted after edge", grant, 4'b0001);
        step(4'b0000, 1'b0, 1'b0);
        check("R8 idle clears", grant, 0);

        // R9: last master kept
        cfg_write(1'b0, 9'd511, 2'd1, 2'd0, 3'd0);
        step(4'b0100, 1'b0, 1'b0);
        check("R3 grant from free", grant, 4'b0100);
        step(4'b0000, 1'b0, 1'b0);
        check("R9 keeps last", grant, 4'b0100);
        pre_edge(4'b0100);
        check("R9 no_wait at once", no_wait, 1);
        @(posedge clk); #1;
        step(4'b0100, 1'b1, 1'b1);
        step(4'b0000, 1'b0, 1'b0);
        check("R9 keeps after access", grant, 4'b0100);

        // R11: locked write ignored
        cfg_write(1'b1, 9'd511, 2'd2, 2'd3, 3'd0);
        step(4'b0000, 1'b0, 1'b0);
        check("R11 locked write ignored", grant, 4'b0100);

        // R10: fixed master
        cfg_write(1'b0, 9'd511, 2'd2, 2'd3, 3'd0);
        step(4'b0000, 1'b0, 1'b0);
        check("R10 fixed master", grant, 4'b1000);
        pre_edge(4'b1000);
        check("R12 fixed no_wait", no_wait, 1);
        @(posedge clk); #1;

        // R8: policy 3 behaves as none
        cfg_write(1'b0, 9'd511, 2'd3, 2'd0, 3'd0);
        step(4'b0000, 1'b0, 1'b0);
        check("R8 policy 3 clears", grant, 0);

        // R4: slot limit 4 with a rival
        cfg_write(1'b0, 9'd4, 2'd0, 2'd0, 3'd0);
        step(4'b0001, 1'b0, 1'b0);
        check("R3 owner 0", grant, 4'b0001);
        for (int k = 1; k <= 4; k++) begin
            step(4'b0011, 1'b1, 1'b0);
            check($sformatf("R4 slot step %0d", k), grant, (k < 4) ? 4'b0001 : 4'b0010);
        end

        // R5: expiry without a rival keeps the owner
        for (int k = 1; k <= 10; k++) begin
            step(4'b0010, 1'b1, 1'b0);
            if (grant !== 4'b0010 || k == 10) check("R5 no gap", grant, 4'b0010);
        end

        // R6: slot limit 0 disables the timer
        @(negedge clk);
        req = 4'b0010; beat = 1'b1; last = 1'b0;
        cfg_write(1'b0, 9'd0, 2'd0, 2'd0, 3'd0);
        for (int k = 1; k <= 20; k++) begin
            step(4'b0011, 1'b1, 1'b0);
            if (grant !== 4'b0010 || k == 20) check("R6 never cut", grant, 4'b0010);
        end
        step(4'b0011, 1'b1, 1'b1);
        check("R3 after last beat", grant, 4'b0001);

        // R7: beat limit code 2 = four beats, idle cycles not counted
        @(negedge clk);
        req = 4'b0001; beat = 1'b0; last = 1'b0;
        cfg_write(1'b0, 9'd0, 2'd0, 2'd0, 3'd2);
        step(4'b0011, 1'b1, 1'b0);
        step(4'b0011, 1'b1, 1'b0);
        step(4'b0011, 1'b0, 1'b0);
        step(4'b0011, 1'b1, 1'b0);
        check("R7 three beats held", grant, 4'b0001);
        step(4'b0011, 1'b1, 1'b0);
        check("R7 fourth beat cuts", grant, 4'b0010);

        // R7: code 1 = one beat
        @(negedge clk);
        req = 4'b0010; beat = 1'b0; last = 1'b0;
        cfg_write(1'b0, 9'd0, 2'd0, 2'd0, 3'd1);
        step(4'b0110, 1'b1, 1'b0);
        check("R7 single beat cuts", grant, 4'b0100);

        step(4'b0000, 1'b0, 1'b0);
        check("R2 idle grant", grant, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule